// File: doc/BRIEF.md
# NAND Address Cycle Sequencer

This block turns one address request into the ordered series of address bytes that a NAND flash expects. A request says whether a column phase is wanted, whether a page address is present, and what that page address is. The sequencer then sends the bytes one at a time over a single-byte valid/ready handshake to the flash bus engine, and flags the byte that closes the address phase.

The column bytes always carry zero, because the surrounding controller only moves whole pages. Two things set how many bytes go out: a page-geometry select (small pages of 512 bytes or large pages of 2048 bytes) and two capacity bits, one for each density threshold. The sequencer latches all of these when it accepts a request. A request that asks for neither a column nor a page completes at once with a done pulse and sends no bytes.

Top module: `nand_addr_seq`

## Requirements
- R1: After reset, `out_valid` and `done` are low and `req_ready` is high.
- R2: With `req_column` set, the first bytes sent are column bytes of value 0x00. There is one such byte when `large_page`=0 and two when `large_page`=1.
- R3: A column byte has `out_last`=1 only when it is the final column byte and `req_page_vld`=0.
- R4: With `req_page_vld` set, the page bytes follow the column bytes in this order: `req_page[7:0]`, then `req_page[15:8]`, then (when present) `req_page[23:16]`.
- R5: The third page byte is sent only if the selected threshold bit was 1 when the request was accepted. With `large_page`=1 the bit is `cap_ge_256m`; with `large_page`=0 it is `cap_ge_64m`. The threshold bit that is not selected has no effect.
- R6: The final page byte has `out_last`=1, and no other page byte does.
- R7: A byte counts as transferred only in a cycle where `out_valid` and `out_ready` are both 1. While `out_valid` is 1 and `out_ready` is 0, `out_byte` and `out_last` stay stable.
- R8: `done` is high for exactly one cycle. That cycle is the one after the last byte is accepted, or the one after a request with neither column nor page is accepted.
- R9: `req_ready` is 1 only when the sequencer is idle. Request inputs and configuration inputs that change after acceptance do not affect the bytes already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Sequencer idle, request is taken |
| req_column | input | 1 | Column cycles wanted |
| req_page_vld | input | 1 | Page address present |
| req_page | input | PAGE_W | Page address |
| large_page | input | 1 | 1 = 2048-byte page, 0 = 512-byte page |
| cap_ge_64m | input | 1 | Capacity is at least 64 MiB (used in small-page mode) |
| cap_ge_256m | input | 1 | Capacity is at least 256 MiB (used in large-page mode) |
| out_valid | output | 1 | Address byte valid |
| out_ready | input | 1 | Bus engine takes byte |
| out_byte | output | 8 | Address byte |
| out_last | output | 1 | Final byte of the address phase |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with the default PAGE_W of 24, so all three page bytes can be seen. It sweeps every combination of column flag, page flag, page mode and both capacity bits, which is 32 cases. Each case runs with an always-ready sink and again with a sink that stalls on a fixed pattern. The expected byte list, the last flags and the done timing are all computed arithmetically from the request, and some inputs are changed in mid-flight to show that the values latched at acceptance are the ones used.

// File: rtl/nand_addr_pkg.sv
// Package: shared slot encoding for the address sequencer.
// Assumes at most two column slots and three page slots per request.
package nand_addr_pkg;
    localparam int SLOT_W = 3;
    typedef enum logic [SLOT_W-1:0] {
        SLOT_COL0  = 3'd0,
        SLOT_COL1  = 3'd1,
        SLOT_PAGE0 = 3'd2,
        SLOT_PAGE1 = 3'd3,
        SLOT_PAGE2 = 3'd4
    } slot_t;
endpackage

// File: rtl/nand_addr_plan.sv
// Module: nand_addr_plan
// Purely combinational. From one request and the configuration it derives
// the first slot, the final slot, and whether any byte goes out at all.
// Assumes the slots run in the order COL0, COL1, PAGE0, PAGE1, PAGE2, and
// that unused slots are skipped by starting late or stopping early.
module nand_addr_plan
    import nand_addr_pkg::*;
(
    input  logic  column,
    input  logic  page_vld,
    input  logic  large_page,
    input  logic  cap_ge_64m,
    input  logic  cap_ge_256m,
    output slot_t first_slot,
    output slot_t final_slot,
    output logic  empty
);
    logic three_page;

    // Select the capacity threshold that applies to the chosen page geometry.
    always_comb begin
        three_page = large_page ? cap_ge_256m : cap_ge_64m;
    end

    // Work out where the sequence starts and where it ends.
    always_comb begin
        empty      = !column && !page_vld;
        first_slot = column ? SLOT_COL0 : SLOT_PAGE0;
        if (page_vld)
            final_slot = three_page ? SLOT_PAGE2 : SLOT_PAGE1;
        else
            final_slot = large_page ? SLOT_COL1 : SLOT_COL0;
    end
endmodule

// File: rtl/nand_addr_mux.sv
// Module: nand_addr_mux
// Combinational byte selector: column slots give zero, page slots give one
// byte lane of the latched page address, chosen in a generate loop.
// Assumes PAGE_W is at least 24 so that all three lanes exist.
module nand_addr_mux
    import nand_addr_pkg::*;
#(
    parameter int PAGE_W = 24
) (
    input  slot_t             slot,
    input  logic [PAGE_W-1:0] page,
    output logic [7:0]        byte_out
);
    localparam int LANES = 3;
    logic [7:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = page[g*8 +: 8];
    end

    // Map the current slot to its address byte.
    always_comb begin
        case (slot)
            SLOT_PAGE0: byte_out = lane[0];
            SLOT_PAGE1: byte_out = lane[1];
            SLOT_PAGE2: byte_out = lane[2];
            default:    byte_out = 8'h00;
        endcase
    end
endmodule

// File: rtl/nand_addr_seq.sv
// Module: nand_addr_seq (top)
// Accepts a request when idle, latches the request and the configuration,
// then walks the slots from the first one to the final one. Each byte goes
// out on a valid/ready handshake, and done pulses one cycle after the last
// handshake, or one cycle after an empty request is accepted.
// Assumes the bus engine holds out_ready independent of out_valid.
module nand_addr_seq
    import nand_addr_pkg::*;
#(
    parameter int PAGE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_column,
    input  logic              req_page_vld,
    input  logic [PAGE_W-1:0] req_page,
    input  logic              large_page,
    input  logic              cap_ge_64m,
    input  logic              cap_ge_256m,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_byte,
    output logic              out_last,
    output logic              done
);
    slot_t             plan_first, plan_final;
    logic              plan_empty;
    slot_t             cur_slot, end_slot;
    logic [PAGE_W-1:0] page_q;
    logic              large_q;
    logic              busy;
    logic              fire;
    logic              accept;

    nand_addr_plan u_plan (
        .column      (req_column),
        .page_vld    (req_page_vld),
        .large_page  (large_page),
        .cap_ge_64m  (cap_ge_64m),
        .cap_ge_256m (cap_ge_256m),
        .first_slot  (plan_first),
        .final_slot  (plan_final),
        .empty       (plan_empty)
    );

    nand_addr_mux #(.PAGE_W(PAGE_W)) u_mux (
        .slot     (cur_slot),
        .page     (page_q),
        .byte_out (out_byte)
    );

    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;
    assign out_valid = busy;
    assign fire      = busy && out_ready;
    assign out_last  = busy && (cur_slot == end_slot);

    // Sequencer state: latch the request on accept, step on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cur_slot <= SLOT_COL0;
            end_slot <= SLOT_COL0;
            page_q   <= '0;
            large_q  <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                page_q   <= req_page;
                large_q  <= large_page;
                cur_slot <= plan_first;
                end_slot <= plan_final;
                busy     <= !plan_empty;
                done     <= plan_empty;
            end else if (fire) begin
                if (cur_slot == end_slot) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else if (cur_slot == SLOT_COL0 && !large_q) begin
                    cur_slot <= SLOT_PAGE0;
                end else begin
                    cur_slot <= slot_t'(cur_slot + 3'd1);
                end
            end
        end
    end

    // Stall holds the presented byte and flag steady (R7).
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_last));

    // Done is a single-cycle pulse (R8).
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Last accepted byte leads to done on the next cycle (R8).
    p_last_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> done && !out_valid);

    // Column slots always carry zero (R2).
    p_col_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (cur_slot == SLOT_COL0 || cur_slot == SLOT_COL1) |-> out_byte == 8'h00);

    // No request is taken while bytes are pending (R9).
    p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !req_ready);
endmodule

// File: tb/nand_addr_seq_test.sv
module nand_addr_seq_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_column, req_page_vld;
    logic [23:0] req_page;
    logic        large_page, cap_ge_64m, cap_ge_256m;
    logic        out_ready;
    logic        req_ready, out_valid, out_last, done;
    logic [7:0]  out_byte;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    nand_addr_seq #(.PAGE_W(24)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_column(req_column), .req_page_vld(req_page_vld), .req_page(req_page),
        .large_page(large_page), .cap_ge_64m(cap_ge_64m), .cap_ge_256m(cap_ge_256m),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
        .out_last(out_last), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one request; stall selects a stalling sink pattern.
    task automatic run(input bit col, input bit pg, input bit lg, input bit c64,
                       input bit c256, input logic [23:0] pa, input bit stall);
        int  nexp, ncol, npg, idx, cyc;
        byte exp_b [5];
        bit  three;
        logic [7:0] held;
        ncol  = col ? (lg ? 2 : 1) : 0;
        three = lg ? c256 : c64;
        npg   = pg ? (three ? 3 : 2) : 0;
        nexp  = ncol + npg;
        for (int i = 0; i < ncol; i++) exp_b[i] = 8'h00;
        for (int i = 0; i < npg; i++) exp_b[ncol+i] = pa[i*8 +: 8];
        @(negedge clk);
        chk(req_ready, "R9 idle ready", req_ready, 1);
        req_valid = 1; req_column = col; req_page_vld = pg; req_page = pa;
        large_page = lg; cap_ge_64m = c64; cap_ge_256m = c256;
        @(negedge clk);
        req_valid = 0;
        // Scramble inputs after acceptance (R9, R5 latched config).
        req_column = ~col; req_page_vld = ~pg; req_page = ~pa;
        large_page = ~lg; cap_ge_64m = ~c64; cap_ge_256m = ~c256;
        if (nexp == 0) begin
            chk(done && !out_valid, "R8 empty done", {out_valid, done}, 1);
            @(negedge clk);
            chk(!done, "R8 single pulse", done, 0);
            return;
        end
        idx = 0; cyc = 0;
        while (idx < nexp && cyc < 100) begin
            out_ready = stall ? (cyc % 3 == 2) : 1'b1;
            #1;
            chk(out_valid, "R7 valid while pending", out_valid, 1);
            chk(!done, "R8 no early done", done, 0);
            if (out_ready) begin
                chk(out_byte == exp_b[idx], (idx < ncol) ? "R2 column byte" : "R4 page byte",
                    out_byte, exp_b[idx]);
                chk(out_last == (idx == nexp-1), (idx < ncol) ? "R3 column last" : "R6 page last",
                    out_last, idx == nexp-1);
                idx++;
            end else begin
                held = out_byte;
                @(negedge clk);
                chk(out_byte == held, "R7 stall hold", out_byte, held);
                cyc++;
                continue;
            end
            @(negedge clk);
            cyc++;
        end
        out_ready = 1'b0;
        chk(done && !out_valid, "R8 done after last", {out_valid, done}, 1);
        chk(idx == nexp, "R5 byte count", idx, nexp);
        @(negedge clk);
        chk(!done, "R8 single pulse", done, 0);
    endtask

    initial begin
        #(4*200000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; req_valid = 0; req_column = 0; req_page_vld = 0; req_page = '0;
        large_page = 0; cap_ge_64m = 0; cap_ge_256m = 0; out_ready = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(!out_valid && !done && req_ready, "R1 reset state",
            {out_valid, done, req_ready}, 1);
        for (int s = 0; s < 2; s++)
            for (int m = 0; m < 32; m++)
                run(m[0], m[1], m[2], m[3], m[4], 24'hA5C300 + 24'(m * 24'h010203), s[0]);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule